// File: doc/BRIEF.md
# Memory Burst Address Sequencer with Zero-Base Override

This block produces the sub-line byte offset for each data transfer of a memory-bus burst that fills or writes back one cache line. By default a burst starts at the offset the processor asked for and walks the line in toggle (XOR) order. When a zero-base request is captured, the burst instead starts at offset zero and walks the line in ascending order. A static width input picks between a narrow (8-byte) and a wide (16-byte) memory data path. The narrow path takes four transfers per 32-byte line and the wide path takes two.

The active-low zero-base request is registered on every clock where the active-low select is inactive. It is registered again on every clock where select and the active-low end-of-cycle input are both asserted. On all other clocks it is held. As a result, a burst that begins on the same edge that first sees select asserted uses the value captured one clock earlier. Select may also stay asserted across back-to-back bursts. A transfer beat counts only when select is asserted. The block also raises an item-reached flag that the processor-side ready logic uses to hold off ready until the requested word has crossed the memory bus.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising edge where `sel_n_i` is 1, the zero-base state becomes active if `zb_n_i` is 0 and inactive if it is 1. It affects `addr_o` from the next cycle on.
- R2: On an edge where `sel_n_i` is 0 and `eoc_n_i` is 1, the zero-base state is held. A burst whose first beat lands on the edge where select is first seen asserted therefore uses the value captured on the edge before.
- R3: On an edge where `sel_n_i` and `eoc_n_i` are both 0, `zb_n_i` is captured again. That value governs the next burst even though select never went inactive.
- R4: With zero-base in force on the narrow bus (`wide_i`=0), the beats carry offsets 0x00, 0x08, 0x10, 0x18 in that order, whatever `req_off_i` is.
- R5: With zero-base in force on the wide bus (`wide_i`=1), the beats carry offsets 0x00, 0x10, in that order.
- R6: Without zero-base, beat k carries offset ((s XOR k) mod N) × W. Here s = `req_off_i` / W at the first beat, W is 8 (narrow) or 16 (wide), and N is 4 (narrow) or 2 (wide).
- R7: A beat is `beat_i`=1 with `sel_n_i`=0 at a rising edge. The first beat raises `busy_o`. After the N-th beat `busy_o` is 0 and the next burst starts over. While `busy_o` is 0, `addr_o` shows the first offset of the next burst.
- R8: `item_ok_o` is 0 until the beat whose offset equals the requested offset, is 1 during that beat, and stays 1 until the burst ends.
- R9: After reset, zero-base is inactive, `busy_o` is 0 and the beat count is zero. `addr_o` then equals `req_off_i` aligned down to W.
- R10: `beat_i` with `sel_n_i`=1 has no effect: neither the beat count nor `busy_o` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_i | input | 1 | Static bus width: 0 = 8-byte, 1 = 16-byte |
| zb_n_i | input | 1 | Active-low zero-base start request |
| sel_n_i | input | 1 | Active-low memory-bus select |
| eoc_n_i | input | 1 | Active-low end-of-cycle |
| beat_i | input | 1 | One memory data transfer this clock |
| req_off_i | input | 5 | Sub-line byte offset the processor requested |
| addr_o | output | 5 | Sub-line offset of the current or next beat |
| busy_o | output | 1 | A burst is in progress |
| item_ok_o | output | 1 | Requested item has crossed the memory bus |

## Verification
The assertions check these properties on every cycle:
- when the zero-base register loads and when it holds;
- that a burst is entered only by a qualified beat;
- that a beat with select inactive leaves the sequencer idle;
- that an idle zero-based sequencer presents offset zero;
- that the item-reached flag, once high, stays high until the burst ends.

Other behaviour can only be shown by the bench's scenarios. This covers the exact offset order in both widths and both modes, the one-clock lag between capture and use when select first asserts, and the recapture at end-of-cycle with select held. The bench compares every output against its reference model on every clock.

// File: rtl/bas_pkg.sv
package bas_pkg;
   typedef enum logic {
      BW_NARROW = 1'b0,
      BW_WIDE   = 1'b1
   } bus_w_e;
endpackage

// File: rtl/bas_zb_capture.sv
module bas_zb_capture (
   input  logic clk,
   input  logic rst_n,
   input  logic zb_n_i,
   input  logic sel_n_i,
   input  logic eoc_n_i,
   output logic zb_q
);
   logic load;
   assign load = sel_n_i | ~eoc_n_i;

   always_ff @(posedge clk) begin
      if (!rst_n)    zb_q <= 1'b0;
      else if (load) zb_q <= ~zb_n_i;
   end
endmodule

// File: rtl/bas_addr_gen.sv
module bas_addr_gen #(
   parameter int LINE_BYTES   = 32,
   parameter int NARROW_BYTES = 8,
   parameter int WIDE_BYTES   = 16,
   localparam int AW = $clog2(LINE_BYTES),
   localparam int CW = $clog2(LINE_BYTES / NARROW_BYTES)
) (
   input  logic          wide_i,
   input  logic          zb_eff,
   input  logic [AW-1:0] req_off_i,
   input  logic [CW-1:0] start_idx,
   input  logic [CW-1:0] k,
   output logic [CW-1:0] req_live,
   output logic [CW-1:0] idx,
   output logic [AW-1:0] addr
);
   import bas_pkg::*;

   logic [CW-1:0] idx_l  [2];
   logic [CW-1:0] ridx_l [2];
   logic [AW-1:0] addr_l [2];

   for (genvar g = 0; g < 2; g++) begin : g_lane
      localparam int BYTES = (g == 0) ? NARROW_BYTES : WIDE_BYTES;
      localparam int SH    = $clog2(BYTES);
      localparam logic [CW-1:0] MASK = CW'(LINE_BYTES / BYTES - 1);
      logic [AW-1:0] shifted;
      assign shifted   = req_off_i >> SH;
      assign ridx_l[g] = shifted[CW-1:0] & MASK;
      assign idx_l[g]  = (zb_eff ? k : (start_idx ^ k)) & MASK;
      assign addr_l[g] = AW'(idx_l[g]) << SH;
   end

   bus_w_e bw;
   assign bw = bus_w_e'(wide_i);

   always_comb begin
      unique case (bw)
         BW_WIDE: begin
            idx      = idx_l[1];
            addr     = addr_l[1];
            req_live = ridx_l[1];
         end
         default: begin
            idx      = idx_l[0];
            addr     = addr_l[0];
            req_live = ridx_l[0];
         end
      endcase
   end
endmodule

// File: rtl/bas_burst_ctrl.sv
module bas_burst_ctrl #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic          last,
   input  logic          match,
   input  logic          zb_q,
   input  logic [CW-1:0] req_live,
   output logic          busy_q,
   output logic          mzb_q,
   output logic          hit_q,
   output logic [CW-1:0] k_q,
   output logic [CW-1:0] start_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         mzb_q   <= 1'b0;
         hit_q   <= 1'b0;
         k_q     <= '0;
         start_q <= '0;
      end else if (fire) begin
         if (!busy_q) begin
            start_q <= req_live;
            mzb_q   <= zb_q;
         end
         if (last) begin
            busy_q <= 1'b0;
            k_q    <= '0;
            hit_q  <= 1'b0;
         end else begin
            busy_q <= 1'b1;
            k_q    <= k_q + 1'b1;
            if (match) hit_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
   parameter int LINE_BYTES   = 32,
   parameter int NARROW_BYTES = 8,
   parameter int WIDE_BYTES   = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wide_i,
   input  logic                          zb_n_i,
   input  logic                          sel_n_i,
   input  logic                          eoc_n_i,
   input  logic                          beat_i,
   input  logic [$clog2(LINE_BYTES)-1:0] req_off_i,
   output logic [$clog2(LINE_BYTES)-1:0] addr_o,
   output logic                          busy_o,
   output logic                          item_ok_o
);
   localparam int AW       = $clog2(LINE_BYTES);
   localparam int N_BEATS  = LINE_BYTES / NARROW_BYTES;
   localparam int W_BEATS  = LINE_BYTES / WIDE_BYTES;
   localparam int CW       = $clog2(N_BEATS);
   localparam logic [CW-1:0] N_LAST = CW'(N_BEATS - 1);
   localparam logic [CW-1:0] W_LAST = CW'(W_BEATS - 1);

   if ((1 << AW) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if ((1 << $clog2(NARROW_BYTES)) != NARROW_BYTES ||
       (1 << $clog2(WIDE_BYTES)) != WIDE_BYTES) begin : g_bad_width
      $error("bus widths must be powers of two");
   end
   if (WIDE_BYTES <= NARROW_BYTES || W_BEATS < 2) begin : g_bad_ratio
      $error("wide bus must exceed narrow and leave at least two beats");
   end

   logic          zb_q, busy_q, mzb_q, hit_q, fire, last, match, zb_eff;
   logic [CW-1:0] k_q, start_q, req_live, idx, start_eff;

   bas_zb_capture u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .zb_n_i  (zb_n_i),
      .sel_n_i (sel_n_i),
      .eoc_n_i (eoc_n_i),
      .zb_q    (zb_q)
   );

   assign zb_eff    = busy_q ? mzb_q : zb_q;
   assign start_eff = busy_q ? start_q : req_live;

   bas_addr_gen #(
      .LINE_BYTES   (LINE_BYTES),
      .NARROW_BYTES (NARROW_BYTES),
      .WIDE_BYTES   (WIDE_BYTES)
   ) u_gen (
      .wide_i    (wide_i),
      .zb_eff    (zb_eff),
      .req_off_i (req_off_i),
      .start_idx (start_eff),
      .k         (k_q),
      .req_live  (req_live),
      .idx       (idx),
      .addr      (addr_o)
   );

   assign fire  = beat_i & ~sel_n_i;
   assign last  = (k_q == (wide_i ? W_LAST : N_LAST));
   assign match = fire & (idx == start_eff);

   bas_burst_ctrl #(.CW(CW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .last     (last),
      .match    (match),
      .zb_q     (zb_q),
      .req_live (req_live),
      .busy_q   (busy_q),
      .mzb_q    (mzb_q),
      .hit_q    (hit_q),
      .k_q      (k_q),
      .start_q  (start_q)
   );

   assign busy_o    = busy_q;
   assign item_ok_o = hit_q | match;
endmodule

// File: rtl/burst_addr_seq_checks.sv
module burst_addr_seq_checks #(
   parameter int AW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          zb_n_i,
   input logic          sel_n_i,
   input logic          eoc_n_i,
   input logic          beat_i,
   input logic [AW-1:0] addr_o,
   input logic          busy_o,
   input logic          item_ok_o,
   input logic          zb_q
);
   p_zb_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n_i |=> (zb_q == !$past(zb_n_i)));

   p_zb_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n_i && eoc_n_i) |=> $stable(zb_q));

   p_zb_eoc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n_i && !eoc_n_i) |=> (zb_q == !$past(zb_n_i)));

   p_zero_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && zb_q) |-> (addr_o == '0));

   p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && beat_i && !sel_n_i) |=> busy_o);

   p_item_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && item_ok_o) |=> (item_ok_o || !busy_o));

   p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !busy_o);

   p_no_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && sel_n_i) |=> !busy_o);
endmodule

bind burst_addr_seq burst_addr_seq_checks #(.AW($clog2(LINE_BYTES))) u_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .zb_n_i    (zb_n_i),
   .sel_n_i   (sel_n_i),
   .eoc_n_i   (eoc_n_i),
   .beat_i    (beat_i),
   .addr_o    (addr_o),
   .busy_o    (busy_o),
   .item_ok_o (item_ok_o),
   .zb_q      (zb_q)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wide_i = 1'b0, zb_n_i = 1'b1, sel_n_i = 1'b1, eoc_n_i = 1'b1, beat_i = 1'b0;
   logic [4:0] req_off_i = 5'd0;
   logic [4:0] addr_o;
   logic busy_o, item_ok_o;

   int checks = 0;
   int errors = 0;

   // behavioural reference state
   int m_zb = 0, m_busy = 0, m_k = 0, m_start = 0, m_mzb = 0, m_hit = 0;

   always #5 clk = ~clk;

   burst_addr_seq dut (
      .clk(clk), .rst_n(rst_n), .wide_i(wide_i), .zb_n_i(zb_n_i),
      .sel_n_i(sel_n_i), .eoc_n_i(eoc_n_i), .beat_i(beat_i),
      .req_off_i(req_off_i), .addr_o(addr_o), .busy_o(busy_o),
      .item_ok_o(item_ok_o)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic zb, input logic sel, input logic eoc,
                       input logic bt, input int r, input logic w, input string tag);
      int step_b, beats, zbe, st, k, idx, reqi, fire, match;
      zb_n_i = zb; sel_n_i = sel; eoc_n_i = eoc; beat_i = bt;
      req_off_i = 5'(r); wide_i = w;
      #1;
      step_b = w ? 16 : 8;
      beats  = 32 / step_b;
      reqi   = (r / step_b) % beats;
      zbe    = m_busy ? m_mzb : m_zb;
      st     = m_busy ? m_start : reqi;
      k      = m_k;
      idx    = zbe ? k : ((st ^ k) % beats);
      fire   = (bt && !sel) ? 1 : 0;
      match  = (fire && idx == st) ? 1 : 0;
      check(tag, "addr_o", int'(addr_o), idx * step_b);
      check(tag, "busy_o", int'(busy_o), m_busy);
      check(tag, "item_ok_o", int'(item_ok_o), (m_hit || match) ? 1 : 0);
      @(posedge clk);
      if (fire) begin
         if (!m_busy) begin m_start = reqi; m_mzb = m_zb; end
         if (m_k == beats - 1) begin m_busy = 0; m_k = 0; m_hit = 0; end
         else begin m_busy = 1; m_k = m_k + 1; if (match) m_hit = 1; end
      end
      if (sel || !eoc) m_zb = zb ? 0 : 1;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state, offset 8 aligned on narrow bus
      step(1, 1, 1, 0, 9, 0, "R9");
      check("R9", "addr_o after reset", int'(addr_o), 8);
      // R1: capture while select inactive, visible next cycle
      step(0, 1, 1, 0, 8, 0, "R1");
      step(0, 1, 1, 0, 16, 0, "R1");
      check("R1", "addr_o zero-based idle", int'(addr_o), 0);
      // R4 / R8: narrow zero-base burst, request offset 0x10
      step(1, 0, 1, 1, 16, 0, "R4");
      step(1, 0, 1, 1, 16, 0, "R4");
      step(1, 0, 1, 1, 16, 0, "R8");
      step(1, 0, 1, 1, 16, 0, "R4");
      step(1, 1, 1, 0, 16, 0, "R7");
      // R6: narrow interleaved from offset 0x18
      step(1, 0, 1, 1, 24, 0, "R6");
      step(1, 0, 1, 1, 24, 0, "R6");
      step(1, 0, 1, 1, 24, 0, "R6");
      step(1, 0, 1, 1, 24, 0, "R6");
      // R5: wide zero-base
      step(0, 1, 1, 0, 16, 1, "R1");
      step(0, 0, 1, 1, 16, 1, "R5");
      step(1, 0, 1, 1, 16, 1, "R5");
      step(1, 1, 1, 0, 16, 1, "R7");
      // R7: wide interleaved from 0x10, then idle
      step(1, 0, 1, 1, 16, 1, "R7");
      step(1, 0, 1, 1, 16, 1, "R7");
      step(1, 0, 1, 0, 16, 1, "R7");
      // R2: select rises with zero-base asserted on the same edge
      step(1, 1, 1, 0, 8, 0, "R2");
      step(0, 0, 1, 1, 8, 0, "R2");
      step(0, 0, 1, 1, 8, 0, "R2");
      step(0, 0, 1, 1, 8, 0, "R2");
      step(0, 0, 1, 1, 8, 0, "R2");
      // R3: select held, end-of-cycle recaptures zero-base
      step(0, 0, 0, 0, 24, 0, "R3");
      step(1, 0, 1, 0, 24, 0, "R3");
      check("R3", "addr_o after recapture", int'(addr_o), 0);
      step(1, 0, 1, 1, 24, 0, "R3");
      step(1, 0, 1, 1, 24, 0, "R8");
      step(1, 0, 1, 1, 24, 0, "R8");
      step(1, 0, 1, 1, 24, 0, "R8");
      // R10: beats with select inactive are ignored, idle and mid-burst
      step(1, 1, 1, 1, 8, 0, "R10");
      step(1, 1, 1, 1, 8, 0, "R10");
      step(1, 0, 1, 1, 8, 0, "R10");
      step(1, 1, 1, 1, 8, 0, "R10");
      step(1, 0, 1, 1, 8, 0, "R10");
      step(1, 0, 1, 1, 8, 0, "R10");
      step(1, 0, 1, 1, 8, 0, "R10");
      step(1, 1, 1, 0, 8, 0, "R10");
      // R6: random traffic, width fixed per block
      for (int blk = 0; blk < 4; blk++) begin
         for (int i = 0; i < 150; i++) begin
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
                 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) != 0),
                 int'($urandom_range(0, 31)), 1'(blk[0]), "R6");
         end
         // drain to idle before switching width
         while (m_busy != 0) step(1, 0, 1, 1, 0, 1'(blk[0]), "R7");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule